// File: doc/BRIEF.md
# Single-Precision Float Packer

This block takes a floating-point value held in a wide working form and produces the 32-bit IEEE-754 single-precision word, together with the overflow, underflow and inexact flags for that conversion. The working form carries a class code, a sign, a signed unbiased exponent, and a mantissa. The mantissa's top bit is the explicit leading one. Below it sit the 23 fraction bits, then at least two more bits, plus a separate sticky input that stands for everything already discarded upstream.

Every value uses one right-alignment shifter, whether it is normal or subnormal. The shifter is followed by a rounding incrementer that takes one of four rounding modes, and by an assembly stage. The assembly stage handles exponent bumps, promotion of a subnormal to the smallest normal, and the mode-dependent choice on overflow. The result and the flags are registered together and appear one clock after `in_vld`. An arithmetic unit uses the block at the end of its pipeline when it writes a single-precision result. A trap-enable input for underflow only affects the flag; trap delivery is left to the caller.

Top module: `sp_packer`

## Requirements
- R1: While reset is asserted and after it is released, with no request made, `out_vld`, `out_word` and all three flags are 0.
- R2: A request with `in_vld` high sets `out_vld` high on the next clock, with the word and flags of that request. A cycle without a request gives `out_vld` low on the following clock.
- R3: Class code 0 (zero), and the unused codes 5 to 7, give `{sign, 31'b0}` with all flags clear.
- R4: Class code 2 (infinity) gives exponent field 255 and fraction 0, with all flags clear.
- R5: Class codes 3 (quiet NaN) and 4 (signalling NaN) give exponent field 255. The fraction is taken from the 23 input bits just below the leading one, with fraction bit 22 forced to 1. All flags are clear.
- R6: For class code 1 (normal), the biased exponent is the input exponent plus 127. The 24-bit significand is rounded under `rnd_mode`: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. Inexact is set when any discarded mantissa bit or `in_stk` is 1.
- R7: When rounding carries the significand to 2.0, the exponent field rises by one and the fraction is 0.
- R8: When the biased exponent is 0 or below, the significand is shifted right by (1 - biased exponent) more places before rounding. The exponent field of the result is 0.
- R9: A subnormal that rounds up into the leading-one position gives exponent field 1 with fraction 0, and underflow stays clear.
- R10: A result that stays subnormal raises underflow when it is inexact or when `uf_trap_en` is 1. Otherwise underflow is clear.
- R11: When the final biased exponent reaches 255 or more, overflow and inexact are both set. Overflow and underflow are never set together.
- R12: On overflow the result is infinity (exponent 255, fraction 0) or the largest finite value (exponent 254, fraction all ones). Infinity is chosen in mode 0, never in mode 1, in mode 2 only for positive values, and in mode 3 only for negative values.
- R13: Bit 31 of the result always equals `in_sign`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Request strobe, one conversion per cycle |
| in_cls | input | 3 | Class code: 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EW | Unbiased exponent, two's complement |
| in_man | input | MW | Mantissa with the explicit leading one at bit MW-1 |
| in_stk | input | 1 | Sticky bit for bits discarded before this block |
| rnd_mode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| uf_trap_en | input | 1 | Underflow trap enable, forces the underflow flag on tiny results |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| out_word | output | 32 | Packed single-precision word |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |

## Verification
The bench builds the block with its defaults: MW = 28, so four mantissa bits fall below the kept field, and EW = 10, so exponents range from -512 to 511. With four extra bits, guard-only ties, ties with lower bits set, and sticky-only inexactness can all be reached on the normal path. The wide exponent range lets random values fall far below the subnormal range, where the whole mantissa collapses into sticky. It also lets them go past 255 after biasing, so the overflow choice is exercised for both signs in all four modes.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;

   localparam int FRAC_W = 23;
   localparam int SIG_W  = FRAC_W + 1;
   localparam int BIAS   = 127;
   localparam int EXP_MAX = 255;

   typedef enum logic [2:0] {
      CLS_ZERO = 3'd0,
      CLS_NORM = 3'd1,
      CLS_INF  = 3'd2,
      CLS_QNAN = 3'd3,
      CLS_SNAN = 3'd4
   } cls_e;

   typedef enum logic [1:0] {
      RM_NEAR = 2'd0,
      RM_ZERO = 2'd1,
      RM_UP   = 2'd2,
      RM_DOWN = 2'd3
   } rmode_e;

   typedef struct packed {
      logic [31:0] word;
      logic        ovf;
      logic        unf;
      logic        inx;
   } pk_res_t;

endpackage

// File: rtl/sp_pack_align.sv
module sp_pack_align
   import sp_pack_pkg::*;
#(
   parameter int MW  = 28,
   parameter int SHW = 6
) (
   input  logic [MW-1:0]    man,
   input  logic             stk,
   input  logic [SHW-1:0]   sh,
   output logic [SIG_W-1:0] kept,
   output logic             grd,
   output logic             stky
);

   if (MW < SIG_W + 2) begin : g_bad_mw
      $error("sp_pack_align: MW must leave guard and round bits");
   end

   logic [MW-1:0] shifted;

   always_comb begin
      shifted = man >> sh;
      kept    = shifted[SIG_W-1:0];
      grd     = 1'b0;
      stky    = stk;
      for (int i = 0; i < MW; i++) begin
         if (i + 1 == int'(sh)) grd = man[i];
         if (i + 1 < int'(sh))  stky = stky | man[i];
      end
   end

endmodule

// File: rtl/sp_pack_round.sv
module sp_pack_round
   import sp_pack_pkg::*;
(
   input  logic [1:0]       mode,
   input  logic             sign,
   input  logic [SIG_W-1:0] kept,
   input  logic             grd,
   input  logic             stky,
   output logic [SIG_W:0]   rnd,
   output logic             inexact
);

   logic up;

   always_comb begin
      inexact = grd | stky;
      unique case (rmode_e'(mode))
         RM_NEAR: up = grd & (stky | kept[0]);
         RM_ZERO: up = 1'b0;
         RM_UP:   up = inexact & ~sign;
         RM_DOWN: up = inexact & sign;
         default: up = 1'b0;
      endcase
      rnd = {1'b0, kept} + {{SIG_W{1'b0}}, up};
   end

endmodule

// File: rtl/sp_pack_assemble.sv
module sp_pack_assemble
   import sp_pack_pkg::*;
(
   input  logic [2:0]        cls,
   input  logic              sign,
   input  logic              sub,
   input  logic signed [31:0] eb,
   input  logic [SIG_W:0]    rnd,
   input  logic              inexact,
   input  logic              trap_en,
   input  logic [1:0]        mode,
   input  logic [FRAC_W-1:0] nan_frac,
   output pk_res_t           res
);

   logic signed [31:0] ef;
   logic               to_inf;

   always_comb begin
      unique case (rmode_e'(mode))
         RM_NEAR: to_inf = 1'b1;
         RM_ZERO: to_inf = 1'b0;
         RM_UP:   to_inf = ~sign;
         RM_DOWN: to_inf = sign;
         default: to_inf = 1'b0;
      endcase
   end

   always_comb begin
      res      = '0;
      ef       = eb + 32'(rnd[SIG_W]);
      res.word = {sign, 31'd0};
      unique case (cls_e'(cls))
         CLS_INF: res.word = {sign, 8'hFF, {FRAC_W{1'b0}}};
         CLS_QNAN, CLS_SNAN:
            res.word = {sign, 8'hFF, 1'b1, nan_frac[FRAC_W-2:0]};
         CLS_NORM: begin
            res.inx = inexact;
            if (sub) begin
               if (rnd[SIG_W-1]) begin
                  res.word = {sign, 8'd1, {FRAC_W{1'b0}}};
               end else begin
                  res.word = {sign, 8'd0, rnd[FRAC_W-1:0]};
                  res.unf  = inexact | trap_en;
               end
            end else if (ef >= EXP_MAX) begin
               res.ovf  = 1'b1;
               res.inx  = 1'b1;
               res.word = to_inf ? {sign, 8'hFF, {FRAC_W{1'b0}}}
                                 : {sign, 8'hFE, {FRAC_W{1'b1}}};
            end else begin
               res.word = {sign, ef[7:0], rnd[FRAC_W-1:0]};
            end
         end
         default: res.word = {sign, 31'd0};
      endcase
   end

endmodule

// File: rtl/sp_packer.sv
module sp_packer
   import sp_pack_pkg::*;
#(
   parameter int MW = 28,
   parameter int EW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [2:0]    in_cls,
   input  logic          in_sign,
   input  logic [EW-1:0] in_exp,
   input  logic [MW-1:0] in_man,
   input  logic          in_stk,
   input  logic [1:0]    rnd_mode,
   input  logic          uf_trap_en,
   output logic          out_vld,
   output logic [31:0]   out_word,
   output logic          out_ovf,
   output logic          out_unf,
   output logic          out_inx
);

   localparam int BASE_SH = MW - SIG_W;
   localparam int SH_MAX  = MW + 1;
   localparam int SHW     = $clog2(SH_MAX + 1) + 1;

   if (MW < SIG_W + 2 || MW > 60) begin : g_bad_mw
      $error("sp_packer: MW out of range");
   end
   if (EW < 9 || EW > 30) begin : g_bad_ew
      $error("sp_packer: EW out of range");
   end

   logic signed [31:0] eb;
   logic               sub;
   logic [SHW-1:0]     sh;
   logic [SIG_W-1:0]   kept;
   logic               grd, stky, inexact;
   logic [SIG_W:0]     rnd;
   pk_res_t            nxt, cur;

   always_comb begin
      int tot;
      eb  = 32'(int'($signed(in_exp)) + BIAS);
      sub = (eb <= 0);
      tot = BASE_SH + (sub ? (1 - int'(eb)) : 0);
      if (tot > SH_MAX) tot = SH_MAX;
      sh  = SHW'(tot);
   end

   sp_pack_align #(.MW(MW), .SHW(SHW)) u_align (
      .man  (in_man),
      .stk  (in_stk),
      .sh   (sh),
      .kept (kept),
      .grd  (grd),
      .stky (stky)
   );

   sp_pack_round u_round (
      .mode    (rnd_mode),
      .sign    (in_sign),
      .kept    (kept),
      .grd     (grd),
      .stky    (stky),
      .rnd     (rnd),
      .inexact (inexact)
   );

   sp_pack_assemble u_asm (
      .cls      (in_cls),
      .sign     (in_sign),
      .sub      (sub),
      .eb       (eb),
      .rnd      (rnd),
      .inexact  (inexact),
      .trap_en  (uf_trap_en),
      .mode     (rnd_mode),
      .nan_frac (in_man[MW-2 -: FRAC_W]),
      .res      (nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         cur     <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) cur <= nxt;
      end
   end

   assign out_word = cur.word;
   assign out_ovf  = cur.ovf;
   assign out_unf  = cur.unf;
   assign out_inx  = cur.inx;

endmodule

// File: rtl/sp_packer_chk.sv
module sp_packer_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_vld,
   input logic        in_sign,
   input logic        out_vld,
   input logic [31:0] out_word,
   input logic        out_ovf,
   input logic        out_unf,
   input logic        out_inx
);

   AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld); // R2
   AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld); // R2
   AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_word[31] == $past(in_sign)); // R13
   AST_OVF_INX: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf |-> out_inx); // R11
   AST_OVF_UNF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_ovf && out_unf)); // R11
   AST_OVF_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf |-> ((out_word[30:23] == 8'hFF && out_word[22:0] == 23'd0) ||
                   (out_word[30:23] == 8'hFE && out_word[22:0] == 23'h7FFFFF))); // R12
   AST_UNF_EXP: assert property (@(posedge clk) disable iff (!rst_n)
      out_unf |-> out_word[30:23] == 8'd0); // R10
   AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (out_word[30:23] == 8'hFF && out_word[22:0] != 23'd0) |-> out_word[22]); // R5

endmodule

bind sp_packer sp_packer_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_vld   (in_vld),
   .in_sign  (in_sign),
   .out_vld  (out_vld),
   .out_word (out_word),
   .out_ovf  (out_ovf),
   .out_unf  (out_unf),
   .out_inx  (out_inx)
);

// File: tb/sim_sp_packer.sv
module sim_sp_packer;

   localparam int MW = 28;
   localparam int EW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_vld = 1'b0;
   logic [2:0]    in_cls = '0;
   logic          in_sign = 1'b0;
   logic [EW-1:0] in_exp = '0;
   logic [MW-1:0] in_man = '0;
   logic          in_stk = 1'b0;
   logic [1:0]    rnd_mode = '0;
   logic          uf_trap_en = 1'b0;
   logic          out_vld;
   logic [31:0]   out_word;
   logic          out_ovf, out_unf, out_inx;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   sp_packer #(.MW(MW), .EW(EW)) u0 (.*);

   function automatic logic [34:0] ref_pack(int cls, bit sg, int ex,
                                            logic [MW-1:0] mn, bit st,
                                            int md, bit tr);
      logic [31:0] w;
      bit ov = 0, un = 0, nx = 0;
      longint v;
      bit g, s, up;
      int eb, drop;
      case (cls)
         2: w = {sg, 8'hFF, 23'd0};
         3, 4: begin
            v = longint'(mn >> (MW - 24)) & 64'h7FFFFF;
            w = {sg, 8'hFF, 23'(v) | 23'h400000};
         end
         1: begin
            eb = ex + 127;
            drop = MW - 24 + ((eb <= 0) ? 1 - eb : 0);
            v = longint'(mn);
            g = 0; s = st;
            for (int k = 0; k < drop; k++) begin
               s = s | g;
               g = v[0];
               v = v >> 1;
            end
            nx = g | s;
            case (md)
               0: up = g && (s || v[0]);
               1: up = 0;
               2: up = nx && !sg;
               default: up = nx && sg;
            endcase
            v = v + longint'(up);
            if (eb <= 0) begin
               if (v >= 64'h800000) w = {sg, 8'd1, 23'd0};
               else begin
                  w = {sg, 8'd0, v[22:0]};
                  un = nx | tr;
               end
            end else begin
               if (v >= 64'h1000000) begin
                  eb = eb + 1;
                  v = 0;
               end
               if (eb >= 255) begin
                  ov = 1; nx = 1;
                  if (md == 0 || (md == 2 && !sg) || (md == 3 && sg))
                     w = {sg, 8'hFF, 23'd0};
                  else
                     w = {sg, 8'hFE, 23'h7FFFFF};
               end else w = {sg, 8'(eb), v[22:0]};
            end
         end
         default: w = {sg, 31'd0};
      endcase
      return {w, ov, un, nx};
   endfunction

   task automatic check(string req, logic [34:0] act, logic [34:0] exp_v);
      total++;
      if (act !== exp_v) begin
         bad++;
         $display("FAIL %s: actual word=%h o/u/x=%b expected word=%h o/u/x=%b",
                  req, act[34:3], act[2:0], exp_v[34:3], exp_v[2:0]);
      end
   endtask

   task automatic conv(int cls, bit sg, int ex, logic [MW-1:0] mn, bit st,
                       int md, bit tr, string req, logic [34:0] exp_v);
      @(negedge clk);
      in_vld = 1; in_cls = 3'(cls); in_sign = sg; in_exp = EW'(ex);
      in_man = mn; in_stk = st; rnd_mode = 2'(md); uf_trap_en = tr;
      @(negedge clk);
      in_vld = 0;
      check(req, {out_word, out_ovf, out_unf, out_inx}, exp_v);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", {out_word, out_ovf, out_unf, out_inx}, 35'd0);
      rst_n = 1;
      @(negedge clk);
      check("R1", {out_vld, out_word, out_ovf, out_unf, out_inx}, 35'd0);

      // R2: valid follows request, drops after idle
      conv(1, 0, 0, 28'h8000000, 0, 0, 0, "R6", {32'h3F800000, 3'b000});
      check("R2", {34'd0, out_vld}, 35'd1);
      @(negedge clk);
      check("R2", {34'd0, out_vld}, 35'd0);

      // R3, R4, R5
      conv(0, 1, 5, 28'hFFFFFFF, 1, 0, 1, "R3", {32'h80000000, 3'b000});
      conv(6, 0, 5, 28'hFFFFFFF, 1, 0, 1, "R3", {32'h00000000, 3'b000});
      conv(2, 1, 0, 28'h8000000, 0, 1, 0, "R4", {32'hFF800000, 3'b000});
      conv(3, 0, 0, 28'h8000000, 0, 0, 0, "R5", {32'h7FC00000, 3'b000});
      conv(4, 0, 0, 28'hA5A5A5A, 0, 0, 0, "R5", {32'h7FE5A5A5, 3'b000});

      // R6: ties and sticky
      conv(1, 0, 0, 28'h8000008, 0, 0, 0, "R6", {32'h3F800000, 3'b001});
      conv(1, 0, 0, 28'h8000018, 0, 0, 0, "R6", {32'h3F800002, 3'b001});
      conv(1, 0, 0, 28'h8000000, 1, 2, 0, "R6", {32'h3F800001, 3'b001});
      conv(1, 0, 0, 28'h8000000, 1, 3, 0, "R6", {32'h3F800000, 3'b001});
      // R7: carry to 2.0
      conv(1, 0, 0, 28'hFFFFFFF, 0, 0, 0, "R7", {32'h40000000, 3'b001});
      // R8, R10: exact subnormal, with and without trap
      conv(1, 0, -130, 28'h8000000, 0, 0, 1, "R10", {32'h00080000, 3'b010});
      conv(1, 0, -130, 28'h8000000, 0, 0, 0, "R8", {32'h00080000, 3'b000});
      conv(1, 0, -400, 28'h9000000, 0, 2, 0, "R10", {32'h00000001, 3'b011});
      conv(1, 1, -400, 28'h9000000, 0, 1, 0, "R10", {32'h80000000, 3'b011});
      // R9: promotion to smallest normal
      conv(1, 0, -127, 28'hFFFFFFF, 0, 0, 0, "R9", {32'h00800000, 3'b001});
      // R11, R12: overflow choices
      conv(1, 0, 127, 28'hFFFFFFF, 0, 0, 0, "R11", {32'h7F800000, 3'b101});
      conv(1, 0, 128, 28'h8000000, 0, 1, 0, "R12", {32'h7F7FFFFF, 3'b101});
      conv(1, 0, 128, 28'h8000000, 0, 2, 0, "R12", {32'h7F800000, 3'b101});
      conv(1, 1, 128, 28'h8000000, 0, 2, 0, "R12", {32'hFF7FFFFF, 3'b101});
      conv(1, 1, 128, 28'h8000000, 0, 3, 0, "R12", {32'hFF800000, 3'b101});
      conv(1, 0, 300, 28'h8000000, 0, 3, 0, "R12", {32'h7F7FFFFF, 3'b101});

      // Random mix against the bench model, with R13 sign check
      for (int n = 0; n < 3000; n++) begin
         int cls, ex, md;
         bit sg, st, tr;
         logic [MW-1:0] mn;
         logic [34:0] e;
         string req;
         cls = ($urandom % 10 < 8) ? 1 : int'($urandom % 8);
         sg = 1'($urandom);
         st = ($urandom % 4 == 0);
         tr = 1'($urandom);
         md = int'($urandom % 4);
         case ($urandom % 4)
            0: ex = int'($urandom % 60) - 170;
            1: ex = int'($urandom % 20) + 120;
            default: ex = int'($urandom % 260) - 130;
         endcase
         mn = MW'($urandom) | {1'b1, {(MW-1){1'b0}}};
         if ($urandom % 5 == 0) mn = mn | 28'h0FFFFF0;
         e = ref_pack(cls, sg, ex, mn, st, md, tr);
         if (e[2]) req = "R12";
         else if (e[1]) req = "R10";
         else if (cls == 1 && ex + 127 <= 0) req = "R8";
         else if (cls == 1) req = "R6";
         else req = "R3";
         conv(cls, sg, ex, mn, st, md, tr, req, e);
         check("R13", {34'd0, out_word[31]}, {34'd0, sg});
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule